// File: doc/BRIEF.md
# Paged-Decoder Mealy Control Unit

This block is a five-state Mealy controller built in two levels. The first level holds a 3-bit state register and combinational logic. From the current state and a 3-bit condition vector, that logic computes the next state and a short 2-bit microinstruction code. The 2-bit code means something only within the current state's decoder page.

The second level is a lookup decoder. It is addressed by the upper two state bits joined with that code, and it expands the code into five microoperation outputs. Two states whose codes differ only in the lowest bit share one decoder page, which halves the decoder's address space. The state register moves on the rising clock edge. The decoder registers its output on the falling edge, so within each cycle the outputs reflect that cycle's state and conditions.

The block is used as a small sequencer. The surrounding logic presents conditions each cycle and reads the microoperation strobes after the mid-cycle edge.

Top module: `mealyPairCtrl`

## Requirements
- R1: While `rst` is high the state is the home state (code 000) and `uopOut` is all zero. The reset acts asynchronously on both stages.
- R2: Bit positions are fixed as follows. `condIn[0]`, `condIn[1]` and `condIn[2]` are conditions c1, c2 and c3. `uopOut[4]` down to `uopOut[0]` are strobes u1 to u5, written in that order below, so 10000 means only u1 is set. The state codes are H=000, P=010, Q=100, S=101 and T=110.
- R3: In H, c1=1 and c2=1 go to P with output 10000. c1=0 and c2=1 go to Q with output 11000. c2=0 goes to S with output 01000.
- R4: In P, c2=1 goes to Q with output 11000, and c2=0 goes to S with output 01000.
- R5: In Q, c2=1 stays in Q with output 01000. c2=0 with c3=0 goes to S with output 01000. c2=0 with c3=1 goes to T with output 01100.
- R6: In S, c3=1 goes to T with output 00110, and c3=0 goes to Q with output 00000.
- R7: In T, c1=1 goes to H with output 10001. c1=0 with c3=1 stays in T with output 00110. c1=0 with c3=0 goes to S with output 01100.
- R8: `uopOut` is captured on the falling clock edge from the state and conditions present then. It does not change when `condIn` moves between that falling edge and the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the state moves on the rising edge, the outputs on the falling edge |
| rst | input | 1 | Asynchronous active-high reset of both stages |
| condIn | input | 3 | Condition inputs c1..c3 (bit 0 is c1) |
| uopOut | output | 5 | Registered microoperation strobes u1..u5 (bit 4 is u1) |

## Verification
Output capture and the state step happen in the same clock period, on opposite edges. Both use the conditions of that period.

The bench applies conditions after a rising edge and checks the outputs after the falling edge against a table-driven model. It then flips the conditions before the next rising edge and confirms that the outputs hold. It restores the conditions in time, so the state step still uses the original values, and the model's predictions for later cycles expose any wrong transition.

Every state is reached from reset and given all eight condition values. Each of those is followed by a short computed walk, so every transition and every output combination is judged.

// File: rtl/mealyPairPkg.sv
package mealyPairPkg;
  localparam int IN_W    = 3;
  localparam int STATE_W = 3;
  localparam int CODE_W  = 2;
  localparam int OUT_W   = 5;
  localparam int PAGE_W  = STATE_W - 1;

  localparam logic [STATE_W-1:0] ST_H = 3'b000;
  localparam logic [STATE_W-1:0] ST_P = 3'b010;
  localparam logic [STATE_W-1:0] ST_Q = 3'b100;
  localparam logic [STATE_W-1:0] ST_S = 3'b101;
  localparam logic [STATE_W-1:0] ST_T = 3'b110;

  // strobes from control to the decoder stage
  typedef struct packed {
    logic              legal;
    logic [PAGE_W-1:0] page;
    logic [CODE_W-1:0] code;
  } strobe_t;
endpackage

// File: rtl/mealyPairControl.sv
module mealyPairControl
  import mealyPairPkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [IN_W-1:0]    xIn,
  output logic [STATE_W-1:0] stateQ,
  output strobe_t            stb
);
  logic [STATE_W-1:0] stateD;
  logic [CODE_W-1:0]  codeD;
  logic               legalD;
  logic c1, c2, c3;

  assign c1 = xIn[0];
  assign c2 = xIn[1];
  assign c3 = xIn[2];

  always_comb begin
    stateD = ST_H;
    codeD  = '0;
    legalD = 1'b1;
    case (stateQ)
      ST_H: begin
        if (c2 && c1)  begin stateD = ST_P; codeD = 2'b00; end
        else if (c2)   begin stateD = ST_Q; codeD = 2'b01; end
        else           begin stateD = ST_S; codeD = 2'b10; end
      end
      ST_P: begin
        if (c2)        begin stateD = ST_Q; codeD = 2'b00; end
        else           begin stateD = ST_S; codeD = 2'b01; end
      end
      ST_Q: begin
        if (c2)        begin stateD = ST_Q; codeD = 2'b00; end
        else if (c3)   begin stateD = ST_T; codeD = 2'b01; end
        else           begin stateD = ST_S; codeD = 2'b00; end
      end
      ST_S: begin
        if (c3)        begin stateD = ST_T; codeD = 2'b10; end
        else           begin stateD = ST_Q; codeD = 2'b11; end
      end
      ST_T: begin
        if (c1)        begin stateD = ST_H; codeD = 2'b10; end
        else if (c3)   begin stateD = ST_T; codeD = 2'b01; end
        else           begin stateD = ST_S; codeD = 2'b00; end
      end
      default: begin
        stateD = ST_H;
        codeD  = '0;
        legalD = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) stateQ <= ST_H;
    else     stateQ <= stateD;
  end

  assign stb.legal = legalD;
  assign stb.page  = stateQ[STATE_W-1:1];
  assign stb.code  = codeD;

  // R3: from H with c2 low the machine lands in S
  assert_h_to_s_R3: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_H && !xIn[1]) |=> (stateQ == ST_S));
  // R4: P is always left for Q or S
  assert_p_exits_R4: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_P) |=> (stateQ == ST_Q || stateQ == ST_S));
  // R6: S with c3 high goes to T
  assert_s_to_t_R6: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_S && xIn[2]) |=> (stateQ == ST_T));
  // R7: T with c1 high returns home
  assert_t_home_R7: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_T && xIn[0]) |=> (stateQ == ST_H));
endmodule

// File: rtl/mealyPairDecoder.sv
module mealyPairDecoder
  import mealyPairPkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  strobe_t          stb,
  output logic [OUT_W-1:0] yQ
);
  logic [OUT_W-1:0] yD;

  always_comb begin
    yD = '0;
    if (stb.legal) begin
      case ({stb.page, stb.code})
        4'b00_00: yD = 5'b10000;
        4'b00_01: yD = 5'b11000;
        4'b00_10: yD = 5'b01000;
        4'b01_00: yD = 5'b11000;
        4'b01_01: yD = 5'b01000;
        4'b10_00: yD = 5'b01000;
        4'b10_01: yD = 5'b01100;
        4'b10_10: yD = 5'b00110;
        4'b10_11: yD = 5'b00000;
        4'b11_00: yD = 5'b01100;
        4'b11_01: yD = 5'b00110;
        4'b11_10: yD = 5'b10001;
        default:  yD = '0;
      endcase
    end
  end

  always_ff @(negedge clk or posedge rst) begin
    if (rst) yQ <= '0;
    else     yQ <= yD;
  end

  // R1: a cleared output stays cleared until the first falling edge after reset
  assert_reset_quiet_R1: assert property (@(negedge clk)
    $fell(rst) |-> (yQ == '0));
endmodule

// File: rtl/mealyPairCtrl.sv
module mealyPairCtrl
  import mealyPairPkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [IN_W-1:0]  condIn,
  output logic [OUT_W-1:0] uopOut
);
  logic [STATE_W-1:0] stateQ;
  strobe_t            stb;

  mealyPairControl u_ctrl (
    .clk(clk), .rst(rst), .xIn(condIn), .stateQ(stateQ), .stb(stb)
  );

  mealyPairDecoder u_dec (
    .clk(clk), .rst(rst), .stb(stb), .yQ(uopOut)
  );

  // R7: T with c1 high yields 10001 on the following falling-edge capture
  assert_t_out_R7: assert property (@(negedge clk) disable iff (rst)
    (stateQ == ST_T && condIn[0]) |=> (uopOut == 5'b10001));
  // R6: S with c3 low yields an all-zero output
  assert_s_quiet_R6: assert property (@(negedge clk) disable iff (rst)
    (stateQ == ST_S && !condIn[2]) |=> (uopOut == 5'b00000));
endmodule

// File: tb/mealyPairCtrl_bench.sv
`timescale 1ns/100ps
module mealyPairCtrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] condIn = 3'b000;
  logic [4:0] uopOut;

  int passCnt = 0;
  int failCnt = 0;
  int mState  = 1;  // 1=H 2=P 3=Q 4=S 5=T

  always #10 clk = ~clk;  // 50 MHz

  mealyPairCtrl u_mealyPairCtrl (
    .clk(clk), .rst(rst), .condIn(condIn), .uopOut(uopOut)
  );

  task automatic check(input logic [4:0] act, input logic [4:0] exp, input string req);
    if (act === exp) passCnt++;
    else begin
      failCnt++;
      $display("FAIL %s: uopOut=%b expected %b", req, act, exp);
    end
  endtask

  function automatic string reqOf(input int s);
    case (s)
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      default: return "R7";
    endcase
  endfunction

  // model: {next state, output} from R2..R7
  function automatic void model(input int s, input logic [2:0] x,
                                output int ns, output logic [4:0] y);
    logic c1, c2, c3;
    c1 = x[0]; c2 = x[1]; c3 = x[2];
    case (s)
      1: if (c1 && c2) begin ns = 2; y = 5'b10000; end
         else if (c2)  begin ns = 3; y = 5'b11000; end
         else          begin ns = 4; y = 5'b01000; end
      2: if (c2) begin ns = 3; y = 5'b11000; end
         else    begin ns = 4; y = 5'b01000; end
      3: if (c2)      begin ns = 3; y = 5'b01000; end
         else if (c3) begin ns = 5; y = 5'b01100; end
         else         begin ns = 4; y = 5'b01000; end
      4: if (c3) begin ns = 5; y = 5'b00110; end
         else    begin ns = 3; y = 5'b00000; end
      default:
         if (c1)      begin ns = 1; y = 5'b10001; end
         else if (c3) begin ns = 5; y = 5'b00110; end
         else         begin ns = 4; y = 5'b01100; end
    endcase
  endfunction

  // entered 2 ns after a rising edge, leaves 2 ns after the next one
  task automatic step(input logic [2:0] xv);
    int ns;
    logic [4:0] ey;
    model(mState, xv, ns, ey);
    #3 condIn = xv;
    @(negedge clk);
    #5 check(uopOut, ey, reqOf(mState));
    #1 condIn = ~xv;
    #1 check(uopOut, ey, "R8");   // output held while conditions move
    #1 condIn = xv;
    @(posedge clk);
    #2 mState = ns;
  endtask

  task automatic doReset();
    rst = 1'b1;
    #2 check(uopOut, 5'b00000, "R1");
    @(posedge clk);
    #2 rst = 1'b0;
    mState = 1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 check(uopOut, 5'b00000, "R1");
    rst = 1'b0;
    // R2: encodings exercised through every state and condition value
    for (int s = 1; s <= 5; s++) begin
      for (int xv = 0; xv < 8; xv++) begin
        doReset();
        case (s)
          2: step(3'b011);
          3: step(3'b010);
          4: step(3'b000);
          5: begin step(3'b000); step(3'b100); end
          default: ;
        endcase
        step(3'(xv));
        for (int k = 1; k <= 4; k++) step(3'((xv * 3 + k * 5 + s) & 7));
      end
    end
    $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
    $finish;
  end

  initial begin
    #(20 * 100000);
    failCnt++;
    $display("FAIL watchdog: run did not complete");
    $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
    $finish;
  end
endmodule